// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block drives a configurable number of 16-pin general-purpose I/O banks from a simple single-cycle register bus. Each bank holds four registers: output data, direction, port mode, and input-buffer enable. A read-only level register shows the synchronized pad inputs.

Output data, direction and port mode can each be written in two ways. A plain write replaces all 16 bits. A masked write uses a 32-bit word in which bits 31:16 select the pins and bits 15:0 give their new values. Software can therefore change one pin in a single bus cycle, with no read-modify-write.

A pin drives its pad only when it is configured as an output in plain GPIO mode. Output data can be loaded first, so that the pad shows the new value from the first cycle its output enable is high.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (input), and output data, port mode and input-buffer enable are 0. Every pad_oe and pad_out bit is 0.
- R2: A write to the data-set group (byte offset 0x100 + 4*bank) changes output bit n to wdata[n] only where wdata[n+16] is 1. All other output bits keep their value.
- R3: A write to the data group (0x000 + 4*bank) loads wdata[15:0] into output data. Reading that address returns the value in bits 15:0, with bits 31:16 zero. pad_out[16*bank+n] always follows output bit n.
- R4: The direction group (0x300 + 4*bank) is read and written plainly. The direction-set group (0x800 + 4*bank) updates it with the R2 masked format. A direction bit of 1 means input and 0 means output.
- R5: The port-mode group (0x400 + 4*bank) is read and written plainly. The port-mode-set group (0x900 + 4*bank) updates it with the R2 masked format. A value of 0 selects plain GPIO.
- R6: pad_oe for a pin is 1 exactly when both its direction bit and its port-mode bit are 0. The change takes effect from the clock edge that accepts the write.
- R7: The level group (0x200 + 4*bank) returns the pad input after a two-flop synchronizer, ANDed with the input-buffer enable (0x4000 + 4*bank, 1 = enabled). A pad change appears after the second rising edge. A disabled pin reads 0.
- R8: Reads of the data-set, direction-set and port-mode-set groups return 0. Writes to the level group change nothing.
- R9: Writes to an unmapped address change no register. Reads of an unmapped address return 0. Unmapped addresses are:
  - any group base other than those listed in R2 to R7;
  - an address whose bits 1:0 are not 00;
  - a bank index (address bits 7:2) of NUM_BANKS or more.
- R10: Banks are independent. Register b of a group sits at the group base + 4*b, and a write to one bank leaves the other banks unchanged.
- R11: When a pin is switched to output, pad_out already holds the preloaded data in the first cycle that pad_oe is 1.

Parameters: NUM_BANKS (number of 16-pin banks, default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 16*NUM_BANKS | Pad input levels |
| pad_out | output | 16*NUM_BANKS | Pad output values |
| pad_oe | output | 16*NUM_BANKS | Pad output enables |

## Verification
Two functions can act on one pin in the same cycle: a direction-set write that turns the pin into an output, and the input synchronizer capturing a new level on that pin's pad. The bench provokes this in one bus cycle. It first loads the pin's output data and enables its input buffer. It then issues the direction-set write on the same edge that the pad input toggles. Before the edge it checks that pad_out already carries the data while pad_oe is still 0. After the edge it checks that pad_oe has risen. Two edges later it checks that the level register shows the new pad value, because the input path is gated only by the buffer enable and not by direction.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int PINS   = 16;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  typedef enum logic [3:0] {
    G_NONE, G_DATA, G_DSET, G_LEVEL, G_DIR, G_PMC, G_DIRSET, G_PMCSET, G_IBUF
  } grp_e;

  // Group selected by address bits 15:8
  function automatic grp_e grp_of(input logic [7:0] g);
    case (g)
      8'h00:   return G_DATA;
      8'h01:   return G_DSET;
      8'h02:   return G_LEVEL;
      8'h03:   return G_DIR;
      8'h04:   return G_PMC;
      8'h08:   return G_DIRSET;
      8'h09:   return G_PMCSET;
      8'h40:   return G_IBUF;
      default: return G_NONE;
    endcase
  endfunction

  // Upper half picks the pins, lower half gives their new values
  function automatic logic [PINS-1:0] masked_merge(input logic [PINS-1:0] cur,
                                                   input logic [DATA_W-1:0] wd);
    logic [PINS-1:0] sel;
    sel = wd[DATA_W-1:PINS];
    return (cur & ~sel) | (wd[PINS-1:0] & sel);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [IDX_W-1:0]  bank_idx,
  output logic              hit
);
  logic aligned;
  logic in_range;

  assign grp      = grp_of(addr[15:8]);
  assign bank_idx = addr[7:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (int'(bank_idx) < NUM_BANKS);
  assign hit      = (grp != G_NONE) && aligned && in_range;
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  grp_e              grp,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   odata,
  output logic [PINS-1:0]   dir,
  output logic [PINS-1:0]   pmc,
  output logic [PINS-1:0]   ibuf,
  output logic [PINS-1:0]   level,
  output logic [PINS-1:0]   oe,
  output logic [PINS-1:0]   dset_mask,
  output logic [PINS-1:0]   rd_val
);
  logic            we;
  logic [PINS-1:0] sync_q;

  assign we = wr & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odata <= '0;
      dir   <= '1;
      pmc   <= '0;
      ibuf  <= '0;
    end else if (we) begin
      case (grp)
        G_DATA:   odata <= wdata[PINS-1:0];
        G_DSET:   odata <= masked_merge(odata, wdata);
        G_DIR:    dir   <= wdata[PINS-1:0];
        G_DIRSET: dir   <= masked_merge(dir, wdata);
        G_PMC:    pmc   <= wdata[PINS-1:0];
        G_PMCSET: pmc   <= masked_merge(pmc, wdata);
        G_IBUF:   ibuf  <= wdata[PINS-1:0];
        default:  ;
      endcase
    end
  end

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (sync_q)
  );

  assign level     = sync_q & ibuf;
  assign oe        = ~(dir | pmc);
  assign dset_mask = (we && grp == G_DSET) ? wdata[DATA_W-1:PINS] : '0;

  always_comb begin
    case (grp)
      G_DATA:  rd_val = odata;
      G_LEVEL: rd_val = level;
      G_DIR:   rd_val = dir;
      G_PMC:   rd_val = pmc;
      G_IBUF:  rd_val = ibuf;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_BANKS*PINS-1:0] pad_in,
  output logic [NUM_BANKS*PINS-1:0] pad_out,
  output logic [NUM_BANKS*PINS-1:0] pad_oe
);
  localparam int TOTAL = NUM_BANKS * PINS;

  grp_e                          grp;
  logic [IDX_W-1:0]              bank_idx;
  logic                          acc_hit;
  logic [NUM_BANKS-1:0]          bank_sel;
  logic [NUM_BANKS-1:0][PINS-1:0] rd_val;
  logic [TOTAL-1:0]              odata_all;
  logic [TOTAL-1:0]              dir_all;
  logic [TOTAL-1:0]              pmc_all;
  logic [TOTAL-1:0]              ibuf_all;
  logic [TOTAL-1:0]              level_all;
  logic [TOTAL-1:0]              dset_mask_all;
  logic [PINS-1:0]               rd_or;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr    (bus_addr),
    .grp     (grp),
    .bank_idx(bank_idx),
    .hit     (acc_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = acc_hit && (bank_idx == IDX_W'(b));
    gpio_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel[b]),
      .wr       (bus_wr),
      .grp      (grp),
      .wdata    (bus_wdata),
      .pad_in   (pad_in[b*PINS +: PINS]),
      .odata    (odata_all[b*PINS +: PINS]),
      .dir      (dir_all[b*PINS +: PINS]),
      .pmc      (pmc_all[b*PINS +: PINS]),
      .ibuf     (ibuf_all[b*PINS +: PINS]),
      .level    (level_all[b*PINS +: PINS]),
      .oe       (pad_oe[b*PINS +: PINS]),
      .dset_mask(dset_mask_all[b*PINS +: PINS]),
      .rd_val   (rd_val[b])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) rd_or = rd_or | rd_val[b];
  end

  assign bus_rdata = {{(DATA_W-PINS){1'b0}}, rd_or};
  assign pad_out   = odata_all;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_BANKS*PINS-1:0] pad_in,
  input logic [NUM_BANKS*PINS-1:0] pad_out,
  input logic [NUM_BANKS*PINS-1:0] pad_oe,
  input logic                      acc_hit,
  input logic [NUM_BANKS*PINS-1:0] odata_all,
  input logic [NUM_BANKS*PINS-1:0] dir_all,
  input logic [NUM_BANKS*PINS-1:0] pmc_all,
  input logic [NUM_BANKS*PINS-1:0] ibuf_all,
  input logic [NUM_BANKS*PINS-1:0] level_all,
  input logic [NUM_BANKS*PINS-1:0] dset_mask_all
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (&dir_all && odata_all == '0 && pmc_all == '0 &&
                             ibuf_all == '0 && pad_oe == '0));

  p_dset_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dset_mask_all) |=> (((odata_all ^ $past(odata_all)) & ~$past(dset_mask_all)) == '0));

  p_oe_output_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & (dir_all | pmc_all)) == '0));

  p_level_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (level_all == ($past(pad_in, 2) & ibuf_all)));

  p_setread_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:8] == 8'h01 || bus_addr[15:8] == 8'h08 || bus_addr[15:8] == 8'h09)
      |-> (bus_rdata == '0));

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !acc_hit) |=> ($stable(odata_all) && $stable(dir_all) &&
                              $stable(pmc_all) && $stable(ibuf_all)));

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> (bus_rdata == '0));

  p_oe_rise_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && |(pad_oe & ~$past(pad_oe))) |->
      ((pad_out & pad_oe & ~$past(pad_oe)) == ($past(pad_out) & pad_oe & ~$past(pad_oe))));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rdata    (bus_rdata),
  .pad_in       (pad_in),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .acc_hit      (acc_hit),
  .odata_all    (odata_all),
  .dir_all      (dir_all),
  .pmc_all      (pmc_all),
  .ibuf_all     (ibuf_all),
  .level_all    (level_all),
  .dset_mask_all(dset_mask_all)
);

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;
  localparam int NB = 4;
  localparam int W  = NB * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_rdata;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_ctrl #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, 64'(v), 64'(exp));
  endtask

  task automatic t_reset;
    expect_reg("R1 dir bank0", 16'h0300, 32'h0000_FFFF);
    expect_reg("R1 dir bank3", 16'h030C, 32'h0000_FFFF);
    expect_reg("R1 data bank0", 16'h0000, 32'h0);
    expect_reg("R1 pmc bank2", 16'h0408, 32'h0);
    expect_reg("R1 ibuf bank1", 16'h4004, 32'h0);
    check("R1 pad_oe", 64'(pad_oe), 64'h0);
    check("R1 pad_out", 64'(pad_out), 64'h0);
  endtask

  task automatic t_plain_data;
    bus_write(16'h0004, 32'hABCD_1234);
    expect_reg("R3 data bank1", 16'h0004, 32'h0000_1234);
    check("R3 pad_out bank1", 64'(pad_out[31:16]), 64'h1234);
    check("R10 bank0 untouched", 64'(pad_out[15:0]), 64'h0);
  endtask

  task automatic t_data_set;
    bus_write(16'h0104, 32'h00FF_00A5);
    expect_reg("R2 low byte", 16'h0004, 32'h0000_12A5);
    bus_write(16'h0104, 32'h8000_8000);
    expect_reg("R2 bit15 set", 16'h0004, 32'h0000_92A5);
    bus_write(16'h0104, 32'h0000_FFFF);
    expect_reg("R2 empty mask", 16'h0004, 32'h0000_92A5);
    check("R2 pad_out", 64'(pad_out[31:16]), 64'h92A5);
  endtask

  task automatic t_direction;
    bus_write(16'h0800, 32'h0003_0001);
    expect_reg("R4 dirset", 16'h0300, 32'h0000_FFFD);
    bus_write(16'h0300, 32'h0000_F0F0);
    expect_reg("R4 plain dir", 16'h0300, 32'h0000_F0F0);
    bus_write(16'h0300, 32'h0000_FFFF);
    expect_reg("R10 dir bank1", 16'h0304, 32'h0000_FFFF);
  endtask

  task automatic t_port_mode;
    bus_write(16'h0908, 32'h000C_0004);
    expect_reg("R5 pmcset", 16'h0408, 32'h0000_0004);
    bus_write(16'h0408, 32'h0000_00FF);
    expect_reg("R5 plain pmc", 16'h0408, 32'h0000_00FF);
    bus_write(16'h0908, 32'h00FF_0000);
    expect_reg("R5 pmcset clear", 16'h0408, 32'h0);
  endtask

  task automatic t_output_enable;
    bus_write(16'h0400, 32'h0000_0002);
    bus_write(16'h0800, 32'h0006_0000);
    check("R6 oe only dir0 pmc0", 64'(pad_oe), 64'h0000_0000_0000_0004);
    bus_write(16'h0900, 32'h0002_0000);
    check("R6 oe after pmc clear", 64'(pad_oe[15:0]), 64'h0006);
    bus_write(16'h0800, 32'h0006_0006);
    check("R6 oe back to input", 64'(pad_oe), 64'h0);
  endtask

  task automatic t_level;
    bus_write(16'h4000, 32'h0000_00FF);
    @(negedge clk);
    bus_addr = 16'h0200;
    pad_in[15:0] = 16'h5A5A;
    @(negedge clk);
    check("R7 one edge still old", 64'(bus_rdata), 64'h0);
    @(negedge clk);
    check("R7 two edges gated", 64'(bus_rdata), 64'h005A);
    bus_write(16'h4000, 32'h0000_FFFF);
    expect_reg("R7 full buffer", 16'h0200, 32'h0000_5A5A);
  endtask

  task automatic t_set_reads;
    expect_reg("R8 dset reads 0", 16'h0104, 32'h0);
    expect_reg("R8 dirset reads 0", 16'h0800, 32'h0);
    expect_reg("R8 pmcset reads 0", 16'h0900, 32'h0);
    bus_write(16'h0200, 32'hFFFF_0000);
    expect_reg("R8 level write ignored", 16'h0200, 32'h0000_5A5A);
    expect_reg("R8 data intact", 16'h0004, 32'h0000_92A5);
  endtask

  task automatic t_unmapped;
    bus_write(16'h0310, 32'h0000_0000);
    expect_reg("R9 bank4 read 0", 16'h0310, 32'h0);
    bus_write(16'h0301, 32'h0000_0000);
    expect_reg("R9 misaligned", 16'h0300, 32'h0000_FFFF);
    bus_write(16'h0500, 32'h0000_FFFF);
    expect_reg("R9 hole read 0", 16'h0500, 32'h0);
    expect_reg("R9 pmc intact", 16'h0400, 32'h0);
    check("R9 pads intact", 64'(pad_oe), 64'h0);
  endtask

  task automatic t_switch_to_output;
    bus_write(16'h400C, 32'h0000_0020);
    bus_write(16'h010C, 32'h0020_0020);
    check("R11 data preloaded", 64'(pad_out[53]), 64'h1);
    @(negedge clk);
    bus_addr  = 16'h080C;
    bus_wdata = 32'h0020_0000;
    bus_wr    = 1'b1;
    pad_in[53] = 1'b1;
    #1;
    check("R11 oe low before edge", 64'(pad_oe[53]), 64'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11 oe high", 64'(pad_oe[53]), 64'h1);
    check("R11 value on pad", 64'(pad_out[53]), 64'h1);
    bus_addr = 16'h020C;
    @(negedge clk);
    check("R7 level with output", 64'(bus_rdata), 64'h0020);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_data();
    t_data_set();
    t_direction();
    t_port_mode();
    t_output_enable();
    t_level();
    t_set_reads();
    t_unmapped();
    t_switch_to_output();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule